// File: doc/BRIEF.md
# Size-Merging Integer ALU

This block is a 64-bit integer execution unit that works on 1, 2, 4 or 8 byte operands. A 2-bit size code selects the operand width. The unit computes a logical, add or subtract result at that width. It then folds the narrow result into a 64-bit destination word. For the two narrow sizes, the untouched upper bytes come from the merge operand `ra`. The 4-byte size zero-fills the upper half, and the 8-byte size replaces the whole word. Condition flags are derived from the narrow value alone, never from the merged 64-bit word.

The inputs are the merge and first operand `ra`, the second operand `rb`, a third operand `rc` with its own carry flag, an opcode and the size. `rc` acts as a mask for the masked variants, and its carry flag feeds the carry variants. A build parameter chooses between a purely combinational path and a single output register. The default build has the output register.

Top module: `szalu_top`

## Requirements
- R1: With size code 0, result bits [7:0] hold the 8-bit operation result and bits [63:8] equal `ra_i[63:8]`.
- R2: With size code 1, result bits [15:0] hold the 16-bit operation result and bits [63:16] equal `ra_i[63:16]`.
- R3: With size code 2, result bits [31:0] hold the 32-bit operation result and bits [63:32] are zero, whatever `ra_i` holds.
- R4: With size code 3, all 64 result bits are the 64-bit operation result.
- R5: `flags_o` is {OF, SF, ZF, PF, CF} from bit 4 down to bit 0. ZF is set when the narrow result is zero. SF is the narrow result's top bit. PF is set when bits [7:0] of the narrow result hold an even number of ones.
- R6: Opcode 9 (add, a+b) and opcode 10 (subtract, a-b) use the low bytes of `ra_i` and `rb_i` at the selected width. CF is the carry out (add) or the borrow (subtract) at that width. OF is signed overflow at that width.
- R7: Opcode 11 (add with carry, a+b+c) and opcode 12 (subtract with borrow, a-b-c) take c from `rc_cf_i`. The data value on `rc_i` has no effect on the result or the flags.
- R8: Opcode 13 (masked add) and opcode 14 (masked subtract) AND the narrow sum or difference with `rc_i` before the merge. ZF, SF and PF follow the masked value. CF and OF follow the arithmetic before masking.
- R9: Logical opcodes act on a=`ra_i` and b=`rb_i`: 0 move b, 1 a&b, 2 a|b, 3 a^b, 4 a&~b, 5 a|~b, 6 ~(a&b), 7 ~(a|b), 8 ~(a^b). These opcodes clear CF and OF.
- R10: With `REG_OUT`=1, outputs show the result of the inputs sampled at the previous rising edge. While `rst_n` is low at an edge, the result and flags become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Opcode |
| size_i | input | 2 | Operand width code: 0=1B, 1=2B, 2=4B, 3=8B |
| ra_i | input | 64 | First operand and merge source |
| rb_i | input | 64 | Second operand |
| rc_i | input | 64 | Mask for masked add/subtract |
| rc_cf_i | input | 1 | Carry flag attached to the third operand |
| res_o | output | 64 | Merged 64-bit result |
| flags_o | output | 5 | {OF, SF, ZF, PF, CF} |

## Verification
The bench uses the defaults: a 64-bit word built from an 8-bit base lane with four lanes, and `REG_OUT`=1. The output register gives the block a one-cycle latency, and that latency makes the registered-output properties and the reset behaviour observable. Every opcode and size pair is run against operand patterns with set sign bits and all-ones fields at every lane width. These patterns reach carry and overflow at each width, and they show whether `ra` leaks into the zero-extended and full-width sizes.

// File: rtl/szalu_pkg.sv
// Shared types for the size-merging ALU.
// Assumes a lane ladder of base width doubling per size code.
package szalu_pkg;
    localparam int BASE_W    = 8;
    localparam int NUM_LANES = 4;
    localparam int XLEN      = BASE_W << (NUM_LANES - 1);
    localparam int SIZE_W    = $clog2(NUM_LANES);

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,  OP_AND  = 4'd1,  OP_OR   = 4'd2,  OP_XOR  = 4'd3,
        OP_ANDN = 4'd4,  OP_ORN  = 4'd5,  OP_NAND = 4'd6,  OP_NOR  = 4'd7,
        OP_EQV  = 4'd8,  OP_ADD  = 4'd9,  OP_SUB  = 4'd10, OP_ADC  = 4'd11,
        OP_SBB  = 4'd12, OP_ADDM = 4'd13, OP_SUBM = 4'd14, OP_RSVD = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic pf;
        logic cf;
    } alu_flags_t;
endpackage

// File: rtl/szalu_logic.sv
// Bitwise unit: computes the full-width logical result.
// Narrowing to the operand width is done later by the merge stage.
module szalu_logic
    import szalu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Select the bitwise function; unknown codes fall back to move.
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ANDN: y = a & ~b;
            OP_ORN:  y = a | ~b;
            OP_NAND: y = ~(a & b);
            OP_NOR:  y = ~(a | b);
            OP_EQV:  y = ~(a ^ b);
            default: y = b;
        endcase
    end
endmodule

// File: rtl/szalu_addsub.sv
// Add/subtract unit: one adder per width lane, so that carry and overflow
// come from each lane's own top bit. Output is zero-extended, masked by rc
// for the masked variants. Assumes op is an arithmetic code when used.
module szalu_addsub
    import szalu_pkg::*;
#(
    parameter int LBASE  = BASE_W,
    parameter int LANES  = NUM_LANES,
    localparam int W     = LBASE << (LANES - 1),
    localparam int SW    = $clog2(LANES)
) (
    input  alu_op_e       op,
    input  logic [SW-1:0] size,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  mask,
    input  logic          cf_in,
    output logic [W-1:0]  y,
    output logic          cf,
    output logic          of
);
    logic          is_sub;
    logic          use_mask;
    logic          cin;
    logic [W-1:0]  lane_sum [LANES];
    logic          lane_co  [LANES];
    logic          lane_of  [LANES];

    // Decode subtract/mask/carry-in from the opcode.
    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_SUBM);
        use_mask = (op == OP_ADDM) || (op == OP_SUBM);
        case (op)
            OP_ADC:  cin = cf_in;
            OP_SUB:  cin = 1'b1;
            OP_SBB:  cin = ~cf_in;
            OP_SUBM: cin = 1'b1;
            default: cin = 1'b0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LW = LBASE << i;
        logic [LW:0]   s;
        logic [LW-1:0] bop;
        assign bop         = is_sub ? ~b[LW-1:0] : b[LW-1:0];
        assign s           = {1'b0, a[LW-1:0]} + {1'b0, bop} + {{LW{1'b0}}, cin};
        assign lane_sum[i] = W'(s[LW-1:0]);
        assign lane_co[i]  = s[LW];
        assign lane_of[i]  = (a[LW-1] == bop[LW-1]) && (s[LW-1] != a[LW-1]);
    end

    // Pick the lane of the selected width and apply the optional mask.
    always_comb begin
        y  = lane_sum[size] & (use_mask ? mask : {W{1'b1}});
        cf = is_sub ? ~lane_co[size] : lane_co[size];
        of = lane_of[size];
    end
endmodule

// File: rtl/szalu_merge.sv
// Merge stage: narrows a raw result to the width of the size code, derives
// ZF/SF/PF from that narrow value, and builds the 64-bit destination.
// Sizes below ZEXT_SIZE keep the upper bytes of the merge source; sizes
// from ZEXT_SIZE up zero-fill them.
module szalu_merge
    import szalu_pkg::*;
#(
    parameter int LBASE     = BASE_W,
    parameter int LANES     = NUM_LANES,
    parameter int ZEXT_SIZE = 2,
    localparam int W        = LBASE << (LANES - 1),
    localparam int SW       = $clog2(LANES)
) (
    input  logic [SW-1:0] size,
    input  logic [W-1:0]  raw,
    input  logic [W-1:0]  merge_src,
    output logic [W-1:0]  merged,
    output logic          zf,
    output logic          sf,
    output logic          pf
);
    logic [W-1:0] wmask;
    logic [W-1:0] narrow;
    int           width;

    // Form the width mask and the narrow value.
    always_comb begin
        width  = LBASE << size;
        wmask  = {W{1'b1}} >> (W - width);
        narrow = raw & wmask;
    end

    // Derive flags from the narrow value only.
    always_comb begin
        zf = (narrow == '0);
        sf = narrow[width-1];
        pf = ~^narrow[LBASE-1:0];
    end

    // Keep or zero the upper bytes according to the size code.
    always_comb begin
        if (int'(size) < ZEXT_SIZE) merged = (merge_src & ~wmask) | narrow;
        else                        merged = narrow;
    end
endmodule

// File: rtl/szalu_top.sv
// Size-merging integer ALU top: logical and add/subtract datapaths, the
// size merge, and an optional output register (REG_OUT=1) with synchronous
// active-low reset. Assumes the opcode encoding of szalu_pkg.
module szalu_top
    import szalu_pkg::*;
#(
    parameter int REG_OUT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [XLEN-1:0]   ra_i,
    input  logic [XLEN-1:0]   rb_i,
    input  logic [XLEN-1:0]   rc_i,
    input  logic              rc_cf_i,
    output logic [XLEN-1:0]   res_o,
    output logic [4:0]        flags_o
);
    alu_op_e         op;
    logic [XLEN-1:0] logic_y;
    logic [XLEN-1:0] arith_y;
    logic            arith_cf;
    logic            arith_of;
    logic            is_arith;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] merged;
    logic            zf, sf, pf;
    alu_flags_t      flags_c;

    assign op = alu_op_e'(op_i);

    szalu_logic #(.W(XLEN)) u_logic (
        .op (op),
        .a  (ra_i),
        .b  (rb_i),
        .y  (logic_y)
    );

    szalu_addsub #(.LBASE(BASE_W), .LANES(NUM_LANES)) u_addsub (
        .op    (op),
        .size  (size_i),
        .a     (ra_i),
        .b     (rb_i),
        .mask  (rc_i),
        .cf_in (rc_cf_i),
        .y     (arith_y),
        .cf    (arith_cf),
        .of    (arith_of)
    );

    // Route the arithmetic or logical result toward the merge stage.
    always_comb begin
        is_arith = (op >= OP_ADD) && (op <= OP_SUBM);
        raw      = is_arith ? arith_y : logic_y;
    end

    szalu_merge #(.LBASE(BASE_W), .LANES(NUM_LANES), .ZEXT_SIZE(2)) u_merge (
        .size      (size_i),
        .raw       (raw),
        .merge_src (ra_i),
        .merged    (merged),
        .zf        (zf),
        .sf        (sf),
        .pf        (pf)
    );

    // Assemble the flag word; logical operations clear CF and OF.
    always_comb begin
        flags_c.of = is_arith & arith_of;
        flags_c.sf = sf;
        flags_c.zf = zf;
        flags_c.pf = pf;
        flags_c.cf = is_arith & arith_cf;
    end

    if (REG_OUT != 0) begin : g_reg
        // Register the merged result and flags.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_o   <= '0;
                flags_o <= '0;
            end else begin
                res_o   <= merged;
                flags_o <= flags_c;
            end
        end

        p_keep_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i == 2'd0) |=> (res_o[XLEN-1:8] == $past(ra_i[XLEN-1:8])));
        p_keep_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i == 2'd1) |=> (res_o[XLEN-1:16] == $past(ra_i[XLEN-1:16])));
        p_zero_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i == 2'd2) |=> (res_o[XLEN-1:32] == '0));
        p_zf_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (size_i == 2'd3) |=> (flags_o[2] == (res_o == '0)));
        p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i == 4'd13 || op_i == 4'd14) && size_i == 2'd3)
            |=> ((res_o & ~$past(rc_i)) == '0));
        p_logic_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i <= 4'd8) |=> (flags_o[4] == 1'b0 && flags_o[0] == 1'b0));
    end else begin : g_comb
        assign res_o   = merged;
        assign flags_o = flags_c;
    end
endmodule

// File: tb/tb_szalu_top.sv
module tb_szalu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [63:0] ra_i = '0, rb_i = '0, rc_i = '0;
    logic        rc_cf_i = 1'b0;
    logic [63:0] res_o;
    logic [4:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    szalu_top #(.REG_OUT(1)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
        .ra_i(ra_i), .rb_i(rb_i), .rc_i(rc_i), .rc_cf_i(rc_cf_i),
        .res_o(res_o), .flags_o(flags_o)
    );

    // Reference: returns {OF,SF,ZF,PF,CF,result}.
    function automatic logic [68:0] ref_model(int op, int sz, logic [63:0] ra,
                                              logic [63:0] rb, logic [63:0] rc, logic cf);
        int w = 8 << sz;
        logic [63:0] m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        logic [63:0] a = ra & m;
        logic [63:0] b = rb & m;
        logic [63:0] r, mg;
        logic [65:0] t;
        logic c = 1'b0, o = 1'b0, bin, zf, sf, pf;
        case (op)
            1: r = a & b;
            2: r = a | b;
            3: r = a ^ b;
            4: r = a & ~b;
            5: r = a | ~b;
            6: r = ~(a & b);
            7: r = ~(a | b);
            8: r = ~(a ^ b);
            9, 11, 13: begin
                bin = (op == 11) ? cf : 1'b0;
                t = 66'(a) + 66'(b) + 66'(bin);
                r = t[63:0];
                c = t[w];
                o = (a[w-1] == b[w-1]) && (r[w-1] != a[w-1]);
            end
            10, 12, 14: begin
                bin = (op == 12) ? cf : 1'b0;
                t = 66'(a) - 66'(b) - 66'(bin);
                r = t[63:0];
                c = (66'(a) < (66'(b) + 66'(bin)));
                o = (a[w-1] != b[w-1]) && (r[w-1] != a[w-1]);
            end
            default: r = b;
        endcase
        r = r & m;
        if (op == 13 || op == 14) r = r & rc;
        zf = (r == 64'd0);
        sf = r[w-1];
        pf = ~^r[7:0];
        mg = (sz < 2) ? ((ra & ~m) | r) : r;
        return {o, sf, zf, pf, c, mg};
    endfunction

    function automatic string req_of(int op, int sz);
        string s;
        if (op <= 8)       s = "R9";
        else if (op <= 10) s = "R6";
        else if (op <= 12) s = "R7";
        else               s = "R8";
        case (sz)
            0: s = {s, "/R1/R5"};
            1: s = {s, "/R2/R5"};
            2: s = {s, "/R3/R5"};
            default: s = {s, "/R4/R5"};
        endcase
        return s;
    endfunction

    task automatic check(string req, logic [68:0] act, logic [68:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual res=%h flags=%b expected res=%h flags=%b",
                     req, act[63:0], act[68:64], exp[63:0], exp[68:64]);
        end
    endtask

    // Drive at negedge, sample one edge later away from posedge.
    task automatic run(int op, int sz, logic [63:0] ra, logic [63:0] rb,
                       logic [63:0] rc, logic cf);
        op_i = 4'(op); size_i = 2'(sz); ra_i = ra; rb_i = rb; rc_i = rc; rc_cf_i = cf;
        @(posedge clk);
        @(negedge clk);
        check(req_of(op, sz), {flags_o, res_o}, ref_model(op, sz, ra, rb, rc, cf));
    endtask

    initial begin
        #(10 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] pats [6];
        logic [68:0] first;
        void'($urandom(32'd20240611));
        pats[0] = 64'h0;                pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h8080_8080_8080_8080; pats[3] = 64'h7F7F_7F7F_7F7F_7F7F;
        pats[4] = 64'h0101_0101_0101_0101; pats[5] = 64'h8000_8000_8000_8000;

        // R10: reset clears outputs even with live inputs.
        op_i = 4'd9; size_i = 2'd3; ra_i = 64'h1234; rb_i = 64'h1; rc_i = '1;
        repeat (3) @(negedge clk);
        check("R10 reset", {flags_o, res_o}, 69'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: one-cycle latency, output holds until the next edge.
        run(9, 3, 64'd5, 64'd7, '1, 1'b0);
        op_i = 4'd0; rb_i = 64'hABCD; #2;
        check("R10 hold", {flags_o, res_o}, ref_model(9, 3, 64'd5, 64'd7, '1, 1'b0));
        @(negedge clk);
        check("R10 latency", {flags_o, res_o}, ref_model(0, 3, 64'd5, 64'hABCD, '1, 1'b0));

        // R7: rc data value has no effect on carry variants.
        for (int op = 11; op <= 12; op++) begin
            run(op, 1, 64'hAAAA_5555_0000_8000, 64'h0000_1111_0000_7FFF, 64'h0, 1'b1);
            first = {flags_o, res_o};
            run(op, 1, 64'hAAAA_5555_0000_8000, 64'h0000_1111_0000_7FFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
            check("R7 rc ignored", {flags_o, res_o}, first);
        end

        // Every opcode/size pair: directed corner patterns plus random.
        for (int op = 0; op <= 14; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int i = 0; i < 6; i++) begin
                    for (int j = 0; j < 6; j += 2) begin
                        run(op, sz, pats[i], pats[(i + j + 1) % 6], pats[(i + 3) % 6], i[0]);
                    end
                end
                for (int k = 0; k < 20; k++) begin
                    run(op, sz, {$urandom, $urandom}, {$urandom, $urandom},
                        {$urandom, $urandom}, 1'($urandom));
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule